// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block produces the serial clock of an I2C bus master from the fast system clock. It works in two stages. A prescaler turns the system clock into a one-cycle enable pulse, the module tick, and every other timing in the block is counted in these ticks. A phase divider then builds the SCL waveform from the ticks. It counts the low phase and the high phase separately, each with its own programmable count.

The prescale value is latched only while the block is disabled, and it comes into force when the block is enabled. Changes to it while the block runs do nothing. The low and high counts are read again at the start of every phase, so new values apply from the next phase boundary.

Two strobes travel alongside SCL. The first fires in the cycle SCL goes low and tells a data shifter that it may now drive the next SDA bit. The second fires in the cycle SCL goes high and marks the start of the window in which SDA must stay still. While the block is disabled, or is not bus master, SCL rests high (released).

Top module: `scl_clkgen`

## Requirements
- R1: While enabled, `mclk_tick` is high for exactly one clock out of every (P+1) clocks, where P is the latched prescale value. It is never high in the cycle after `enable` was low.
- R2: The prescale value is captured continuously while `enable` is 0. A new value takes effect from the next 0-to-1 transition of `enable`.
- R3: A change of `psc_value` while `enable` is 1 has no effect on the tick period or on the SCL phase widths.
- R4: The SCL low phase lasts (L+5) ticks, i.e. (L+5)*(P+1) clocks, where L is `low_count`. SCL changes level only in the cycle after a tick while the block is enabled and master.
- R5: The SCL high phase lasts (H+5)*(P+1) clocks, where H is `high_count`, independently of L.
- R6: While `enable` is 0, SCL is 1, `mclk_tick` and both strobes are 0, and all counters are cleared. After re-enabling, a full low phase follows the first tick.
- R7: While `master` is 0, SCL stays 1 and neither strobe fires. When `master` returns to 1, normal SCL periods resume.
- R8: `sda_upd_stb` is a single-clock pulse in exactly the cycle SCL falls, and SCL is 0 while it is high. `scl_hi_stb` is a single-clock pulse in exactly the cycle SCL rises. Each fires exactly once per SCL period.
- R9: With a 100 MHz system clock and prescale value 9, the measured module tick rate is 10 MHz, which lies inside the 7 to 12 MHz operating range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable; 0 holds the block in reset and latches the prescale value |
| master | input | 1 | 1 when the block acts as bus master and drives SCL |
| psc_value | input | PSC_W | Prescale value P; the divide ratio is P+1 |
| low_count | input | CNT_W | Low phase count L; the low phase is L+5 ticks |
| high_count | input | CNT_W | High phase count H; the high phase is H+5 ticks |
| mclk_tick | output | 1 | One-clock module tick enable |
| scl_out | output | 1 | SCL level; 1 means released |
| sda_upd_stb | output | 1 | Pulse at the SCL fall; SDA may change |
| scl_hi_stb | output | 1 | Pulse at the SCL rise; SDA must hold |

## Verification
The bench sweeps several prescale values, including a divide-by-one setting, against several low and high counts. It measures each phase width in clocks against (count+5)*(P+1). An off-by-one in either counter, or swapped count fields, would show up as a wrong width in exactly one phase.

A prescale write while the block runs is followed by a fresh width and tick measurement. A divider that reloads the value live would shorten both. The bench then re-enables the block and checks that the same value now applies, which catches a latch that never updates.

Dropping `enable` and dropping `master` in the middle of a period must leave SCL released and the strobes silent. A strobe that is misaligned by one cycle, or that fires twice per period, is caught by counting strobes in each measured phase.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // fixed number of ticks added to each programmed phase count
  localparam int unsigned PHASE_EXTRA = 5;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PSC_W-1:0] psc_in,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_hold;
  logic [PSC_W-1:0] div_cnt;

  // the divide value follows the input only while disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_hold <= '0;
      div_cnt  <= '0;
      tick_o   <= 1'b0;
    end else if (!enable) begin
      psc_hold <= psc_in;
      div_cnt  <= '0;
      tick_o   <= 1'b0;
    end else if (div_cnt == psc_hold) begin
      div_cnt  <= '0;
      tick_o   <= 1'b1;
    end else begin
      div_cnt  <= div_cnt + 1'b1;
      tick_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/scl_phase_div.sv
module scl_phase_div
  import scl_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  output logic             scl_o,
  output logic             upd_stb_o,
  output logic             hi_stb_o
);
  localparam int unsigned LIM_W = CNT_W + 1;

  scl_phase_e       phase;
  logic [LIM_W-1:0] ph_cnt;
  logic [LIM_W-1:0] ph_lim;
  logic [LIM_W-1:0] low_lim;
  logic [LIM_W-1:0] high_lim;
  logic             ph_done;

  // terminal count of a phase lasting (count + PHASE_EXTRA) ticks
  assign low_lim  = {1'b0, low_cnt}  + LIM_W'(PHASE_EXTRA - 1);
  assign high_lim = {1'b0, high_cnt} + LIM_W'(PHASE_EXTRA - 1);
  assign ph_done  = (ph_cnt == ph_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      ph_cnt    <= '0;
      ph_lim    <= '0;
      scl_o     <= 1'b1;
      upd_stb_o <= 1'b0;
      hi_stb_o  <= 1'b0;
    end else begin
      upd_stb_o <= 1'b0;
      hi_stb_o  <= 1'b0;
      if (!run) begin
        phase  <= PH_IDLE;
        ph_cnt <= '0;
        ph_lim <= '0;
        scl_o  <= 1'b1;
      end else if (tick) begin
        unique case (phase)
          PH_IDLE: begin
            phase     <= PH_LOW;
            ph_cnt    <= '0;
            ph_lim    <= low_lim;
            scl_o     <= 1'b0;
            upd_stb_o <= 1'b1;
          end
          PH_LOW: begin
            if (ph_done) begin
              phase    <= PH_HIGH;
              ph_cnt   <= '0;
              ph_lim   <= high_lim;
              scl_o    <= 1'b1;
              hi_stb_o <= 1'b1;
            end else begin
              ph_cnt <= ph_cnt + 1'b1;
            end
          end
          PH_HIGH: begin
            if (ph_done) begin
              phase     <= PH_LOW;
              ph_cnt    <= '0;
              ph_lim    <= low_lim;
              scl_o     <= 1'b0;
              upd_stb_o <= 1'b1;
            end else begin
              ph_cnt <= ph_cnt + 1'b1;
            end
          end
          default: begin
            phase  <= PH_IDLE;
            ph_cnt <= '0;
            scl_o  <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             master,
  input  logic [PSC_W-1:0] psc_value,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  output logic             mclk_tick,
  output logic             scl_out,
  output logic             sda_upd_stb,
  output logic             scl_hi_stb
);
  logic run;

  assign run = enable & master;

  scl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .psc_in (psc_value),
    .tick_o (mclk_tick)
  );

  scl_phase_div #(.CNT_W(CNT_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (mclk_tick),
    .low_cnt   (low_count),
    .high_cnt  (high_count),
    .scl_o     (scl_out),
    .upd_stb_o (sda_upd_stb),
    .hi_stb_o  (scl_hi_stb)
  );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic master,
  input logic mclk_tick,
  input logic scl_out,
  input logic sda_upd_stb,
  input logic scl_hi_stb
);
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_tick |-> $past(enable)); // R1

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !$past(enable)) |-> (scl_out && !mclk_tick && !sda_upd_stb && !scl_hi_stb)); // R6

  AST_SLAVE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !$past(master)) |-> (scl_out && !sda_upd_stb && !scl_hi_stb)); // R7

  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && master && $past(master) && !$stable(scl_out)) |-> $past(mclk_tick)); // R4

  AST_FALL_HAS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_out) |-> sda_upd_stb); // R8

  AST_UPD_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd_stb |-> (!scl_out && $fell(scl_out))); // R8

  AST_HI_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hi_stb |-> (scl_out && $rose(scl_out))); // R8

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sda_upd_stb, scl_hi_stb})); // R8
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .master      (master),
  .mclk_tick   (mclk_tick),
  .scl_out     (scl_out),
  .sda_upd_stb (sda_upd_stb),
  .scl_hi_stb  (scl_hi_stb)
);

// File: tb/test_scl_clkgen.sv
module test_scl_clkgen;
  localparam int CLK_NS = 10;
  localparam int PSC_W  = 8;
  localparam int CNT_W  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             master = 1'b1;
  logic [PSC_W-1:0] psc_value = '0;
  logic [CNT_W-1:0] low_count = '0;
  logic [CNT_W-1:0] high_count = '0;
  logic             mclk_tick, scl_out, sda_upd_stb, scl_hi_stb;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  scl_clkgen #(.PSC_W(PSC_W), .CNT_W(CNT_W)) i_scl_clkgen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master(master),
    .psc_value(psc_value), .low_count(low_count), .high_count(high_count),
    .mclk_tick(mclk_tick), .scl_out(scl_out),
    .sda_upd_stb(sda_upd_stb), .scl_hi_stb(scl_hi_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input int p, input int l, input int h);
    @(negedge clk);
    enable = 1'b0;
    psc_value = PSC_W'(p);
    low_count = CNT_W'(l);
    high_count = CNT_W'(h);
    repeat (3) @(negedge clk);
    enable = 1'b1;
  endtask

  // clocks between two consecutive ticks
  task automatic tick_period(output int n);
    while (mclk_tick !== 1'b1) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (mclk_tick !== 1'b1);
  endtask

  // one full SCL period starting at a falling edge
  task automatic measure(output int lw, output int hw, output int ups,
                         output int his, output bit upd_first);
    lw = 0; hw = 0; ups = 0; his = 0;
    while (scl_out !== 1'b1) @(negedge clk);
    while (scl_out !== 1'b0) @(negedge clk);
    upd_first = sda_upd_stb;
    while (scl_out === 1'b0) begin
      lw++;
      if (sda_upd_stb) ups++;
      if (scl_hi_stb) his++;
      @(negedge clk);
    end
    while (scl_out === 1'b1) begin
      hw++;
      if (sda_upd_stb) ups++;
      if (scl_hi_stb) his++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lw, hw, ups, his, n;
    bit uf;
    int psc_set[4] = '{0, 1, 3, 9};
    int cnt_set[3] = '{0, 2, 7};

    repeat (3) @(negedge clk);
    // R6 reset state
    check(scl_out === 1'b1 && mclk_tick === 1'b0 && sda_upd_stb === 1'b0 && scl_hi_stb === 1'b0,
          "R6 reset state", int'(scl_out), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(scl_out === 1'b1 && mclk_tick === 1'b0, "R6 idle after reset", int'(scl_out), 1);

    // sweep prescale and phase counts
    foreach (psc_set[pi]) begin
      foreach (cnt_set[li]) begin
        foreach (cnt_set[hi]) begin
          configure(psc_set[pi], cnt_set[li], cnt_set[hi]);
          tick_period(n);
          check(n == psc_set[pi] + 1, "R1 tick period", n, psc_set[pi] + 1);
          measure(lw, hw, ups, his, uf);
          check(lw == (cnt_set[li] + 5) * (psc_set[pi] + 1), "R4 low width", lw,
                (cnt_set[li] + 5) * (psc_set[pi] + 1));
          check(hw == (cnt_set[hi] + 5) * (psc_set[pi] + 1), "R5 high width", hw,
                (cnt_set[hi] + 5) * (psc_set[pi] + 1));
          check(ups == 1 && his == 1 && uf, "R8 strobes per period", ups * 10 + his, 11);
        end
      end
    end

    // R9 operating frequency with 100 MHz input and prescale 9
    configure(9, 3, 5);
    tick_period(n);
    check(n > 0 && (1000000 / (n * CLK_NS)) >= 7000 && (1000000 / (n * CLK_NS)) <= 12000,
          "R9 module clock kHz", (n > 0) ? 1000000 / (n * CLK_NS) : 0, 10000);

    // R3 prescale change while running is ignored
    @(negedge clk);
    psc_value = PSC_W'(2);
    tick_period(n);
    check(n == 10, "R3 tick period after live write", n, 10);
    measure(lw, hw, ups, his, uf);
    check(lw == 80, "R3 low width after live write", lw, 80);
    check(hw == 100, "R3 high width after live write", hw, 100);

    // R2 the held value applies after re-enable
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    tick_period(n);
    check(n == 3, "R2 tick period after re-enable", n, 3);
    measure(lw, hw, ups, his, uf);
    check(lw == 24 && hw == 30, "R2 widths after re-enable", lw * 1000 + hw, 24030);

    // R6 disable mid-period
    repeat (7) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    n = 0;
    repeat (40) begin
      @(negedge clk);
      if (scl_out !== 1'b1 || mclk_tick !== 1'b0 || sda_upd_stb !== 1'b0 || scl_hi_stb !== 1'b0) n++;
    end
    check(n == 0, "R6 outputs quiet while disabled", n, 0);
    enable = 1'b1;
    measure(lw, hw, ups, his, uf);
    check(lw == 24 && hw == 30, "R6 full period after re-enable", lw * 1000 + hw, 24030);

    // R7 not master
    repeat (5) @(negedge clk);
    master = 1'b0;
    @(negedge clk);
    n = 0;
    repeat (60) begin
      @(negedge clk);
      if (scl_out !== 1'b1 || sda_upd_stb !== 1'b0 || scl_hi_stb !== 1'b0) n++;
    end
    check(n == 0, "R7 SCL released when not master", n, 0);
    master = 1'b1;
    measure(lw, hw, ups, his, uf);
    check(lw == 24 && hw == 30 && ups == 1 && his == 1, "R7 periods resume",
          lw * 1000 + hw, 24030);

    // R4 R5 new counts apply at the next phase boundary
    @(negedge clk);
    low_count = CNT_W'(1);
    high_count = CNT_W'(6);
    measure(lw, hw, ups, his, uf);
    measure(lw, hw, ups, his, uf);
    check(lw == 18, "R4 low width after count change", lw, 18);
    check(hw == 33, "R5 high width after count change", hw, 33);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule